// File: doc/BRIEF.md
# Handshaked Byte-Serial Link Engine

This block is the host end of a byte-wide serial channel to a power-management microcontroller. An upper layer gives it one command at a time: send a byte, or receive a byte. The engine loads its internal shifter, pulls the active-low request line low, and then moves one bit for each rising edge of the shift clock that the microcontroller supplies. After the last bit it releases the request line. It then waits, with a bounded cycle count, for the microcontroller to release its active-low acknowledge line.

The transfer ends in one of two ways. A single-cycle done pulse reports success, and for a receive it comes with the captured byte. A single-cycle timeout pulse reports that the microcontroller stopped responding. If acknowledge is already released at the moment the last bit completes, a one-cycle anomaly flag is raised and the transfer still finishes normally.

A new command is taken only when the engine is idle and has seen acknowledge high. The serial inputs and the acknowledge line are resynchronised to the host clock before use.

Top module: `link_engine`

## Requirements
- R1: While reset is held and right after it, link_req_n is 1 and xfer_done, xfer_timeout, rx_valid and ack_anomaly are 0. cmd_ready rises within a few cycles once link_ack_n is 1.
- R2: A command is accepted only when the engine is idle and the synchronised link_ack_n is 1. While link_ack_n is 0, cmd_ready is 0, cmd_valid has no effect, and link_req_n stays 1.
- R3: The cycle after an accepted command, link_req_n is 0. It stays 0 until the DATA_W-th rising edge of shift_clk has been seen.
- R4: Send (cmd_rx=0): shift_out_en is 1 and shift_dout carries cmd_wdata most significant bit first. Each following bit appears after a rising edge of shift_clk.
- R5: Receive (cmd_rx=1): shift_din is sampled on each rising edge of shift_clk, most significant bit first. The assembled byte is on rx_data when rx_valid pulses.
- R6: After the last shift edge, link_req_n returns to 1 and further shift_clk edges have no effect until the next command.
- R7: Once link_ack_n is seen at 1 after release, xfer_done pulses for exactly one cycle. rx_valid pulses with it only for a receive.
- R8: If link_ack_n stays 0 for TIMEOUT_CYCLES cycles after link_req_n returns high, xfer_timeout pulses once, exactly TIMEOUT_CYCLES cycles after the release. No done pulse follows, and the engine becomes idle.
- R9: If link_ack_n is already 1 when the last bit completes, ack_anomaly pulses in the same cycle that link_req_n rises, and the transfer still ends with xfer_done.
- R10: shift_clk edges while idle do not change the next transfer's data.
- R11: xfer_done and xfer_timeout are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Upper layer presents a command |
| cmd_rx | input | 1 | 1 = receive a byte, 0 = send cmd_wdata |
| cmd_wdata | input | DATA_W | Byte to send |
| cmd_ready | output | 1 | Engine idle and acknowledge seen high |
| link_req_n | output | 1 | Active-low transfer request to the microcontroller |
| link_ack_n | input | 1 | Active-low acknowledge from the microcontroller |
| shift_clk | input | 1 | Shift clock from the microcontroller |
| shift_din | input | 1 | Serial data into the host |
| shift_dout | output | 1 | Serial data out of the host (1 when not sending) |
| shift_out_en | output | 1 | High while the shifter is driving shift_dout |
| xfer_done | output | 1 | One-cycle success pulse |
| xfer_timeout | output | 1 | One-cycle not-responding pulse |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a received byte |
| rx_data | output | DATA_W | Last received byte |
| ack_anomaly | output | 1 | One-cycle flag: acknowledge already high at completion |

## Verification
The bound checker watches the port-level rules on every cycle. It checks the request line against ready, that an accepted command drops the request, that done and timeout are single exclusive pulses, that rx_valid only rides on done, and that the anomaly flag lines up with the request release. Bit order, the received byte value, the exact timeout distance, the gating of commands by acknowledge, and the immunity to stray shift edges depend on data and on the sequence of events. These can only be shown by the bench's directed scenarios, which play the microcontroller side.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SHIFT   = 2'd1,
    ST_RELEASE = 2'd2
  } link_state_e;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int                 STAGES  = 2,
  parameter int                 WIDTH   = 1,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/link_shifter.sv
module link_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [DATA_W-1:0] par_q,
  output logic              ser_out
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    sh_en = load_en | shift_en;
    sh_d  = load_en ? load_val : {sh_q[DATA_W-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign par_q   = sh_q;
  assign ser_out = sh_q[DATA_W-1];
endmodule

// File: rtl/link_ack_timer.sv
module link_ack_timer #(
  parameter int LIMIT = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expired = run && (cnt_q == LAST);
    cnt_en  = !run || !expired;
    cnt_d   = run ? cnt_q + TW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/link_engine.sv
module link_engine
  import link_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 4000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rx,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              link_req_n,
  input  logic              link_ack_n,
  input  logic              shift_clk,
  input  logic              shift_din,
  output logic              shift_dout,
  output logic              shift_out_en,
  output logic              xfer_done,
  output logic              xfer_timeout,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_anomaly
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  // synchronised line bundle: {shift_clk, shift_din, link_ack_n}
  logic [2:0] raw_lines, sync_lines;
  logic       sclk_s, din_s, ack_hi_s;
  logic       sclk_prev_q;
  logic       shift_edge;

  assign raw_lines = {shift_clk, shift_din, link_ack_n};

  link_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b000)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_lines),
    .q    (sync_lines)
  );

  assign sclk_s   = sync_lines[2];
  assign din_s    = sync_lines[1];
  assign ack_hi_s = sync_lines[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign shift_edge = sclk_s & ~sclk_prev_q;

  // state registers
  link_state_e       state_q, state_d;
  logic              req_n_q, req_n_d;
  logic              rx_mode_q, rx_mode_d;
  logic [CW-1:0]     bit_q, bit_d;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;
  logic              rxv_q, rxv_d;
  logic              anom_q, anom_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              rxd_en;

  // shifter controls
  logic              sh_load, sh_shift;
  logic [DATA_W-1:0] sh_load_val, sh_par;
  logic              sh_ser;
  logic              accept, last_edge, tmr_run, tmr_exp;

  link_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (sh_load),
    .load_val(sh_load_val),
    .shift_en(sh_shift),
    .ser_in  (din_s & rx_mode_q),
    .par_q   (sh_par),
    .ser_out (sh_ser)
  );

  link_ack_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .expired(tmr_exp)
  );

  assign cmd_ready = (state_q == ST_IDLE) && ack_hi_s;
  assign accept    = cmd_valid && cmd_ready;
  assign last_edge = (state_q == ST_SHIFT) && shift_edge && (bit_q == LAST_BIT);
  assign tmr_run   = (state_q == ST_RELEASE);

  always_comb begin
    state_d     = state_q;
    req_n_d     = req_n_q;
    rx_mode_d   = rx_mode_q;
    bit_d       = bit_q;
    done_d      = 1'b0;
    tmo_d       = 1'b0;
    rxv_d       = 1'b0;
    anom_d      = 1'b0;
    rxd_d       = {sh_par[DATA_W-2:0], din_s};
    rxd_en      = 1'b0;
    sh_load     = 1'b0;
    sh_load_val = cmd_rx ? '0 : cmd_wdata;
    sh_shift    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          sh_load   = 1'b1;
          rx_mode_d = cmd_rx;
          bit_d     = '0;
          req_n_d   = 1'b0;
          state_d   = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (shift_edge) begin
          sh_shift = 1'b1;
          bit_d    = bit_q + CW'(1);
        end
        if (last_edge) begin
          req_n_d = 1'b1;
          anom_d  = ack_hi_s;
          rxd_en  = rx_mode_q;
          state_d = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (ack_hi_s) begin
          done_d  = 1'b1;
          rxv_d   = rx_mode_q;
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        req_n_d = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_n_q   <= 1'b1;
      rx_mode_q <= 1'b0;
      bit_q     <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      rxv_q     <= 1'b0;
      anom_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_n_q   <= req_n_d;
      rx_mode_q <= rx_mode_d;
      bit_q     <= bit_d;
      done_q    <= done_d;
      tmo_q     <= tmo_d;
      rxv_q     <= rxv_d;
      anom_q    <= anom_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rxd_q <= '0;
    else if (rxd_en) rxd_q <= rxd_d;
  end

  assign link_req_n   = req_n_q;
  assign shift_out_en = (state_q == ST_SHIFT) && !rx_mode_q;
  assign shift_dout   = shift_out_en ? sh_ser : 1'b1;
  assign xfer_done    = done_q;
  assign xfer_timeout = tmo_q;
  assign rx_valid     = rxv_q;
  assign rx_data      = rxd_q;
  assign ack_anomaly  = anom_q;
endmodule

// File: rtl/link_engine_chk.sv
module link_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_rx,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              cmd_ready,
  input logic              link_req_n,
  input logic              link_ack_n,
  input logic              shift_clk,
  input logic              shift_din,
  input logic              shift_dout,
  input logic              shift_out_en,
  input logic              xfer_done,
  input logic              xfer_timeout,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              ack_anomaly
);
  assert_ready_needs_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> link_req_n);

  assert_accept_drops_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !link_req_n);

  assert_release_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_req_n) |-> !cmd_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_rxv_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> xfer_done);

  assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_timeout |=> !xfer_timeout);

  assert_anomaly_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_anomaly |-> $rose(link_req_n));

  assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_timeout));

  assert_end_req_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done || xfer_timeout) |-> link_req_n);
endmodule

bind link_engine link_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/link_engine_tb.sv
`timescale 1ns/1ps
module link_engine_tb;
  localparam int DW = 8;
  localparam int TO = 40;

  logic          clk, rst_n;
  logic          cmd_valid, cmd_rx;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_ready, link_req_n, link_ack_n;
  logic          shift_clk, shift_din, shift_dout, shift_out_en;
  logic          xfer_done, xfer_timeout, rx_valid, ack_anomaly;
  logic [DW-1:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt, tmo_cnt, rxv_cnt, anom_cnt, both_cnt;
  int rel_cnt = 0;
  int tmo_at;
  logic [DW-1:0] rx_seen;
  bit finished = 0;

  link_engine #(.DATA_W(DW), .SYNC_STAGES(2), .TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rx(cmd_rx),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .link_req_n(link_req_n),
    .link_ack_n(link_ack_n), .shift_clk(shift_clk), .shift_din(shift_din),
    .shift_dout(shift_dout), .shift_out_en(shift_out_en), .xfer_done(xfer_done),
    .xfer_timeout(xfer_timeout), .rx_valid(rx_valid), .rx_data(rx_data),
    .ack_anomaly(ack_anomaly)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (xfer_done) done_cnt++;
    if (xfer_timeout) begin tmo_cnt++; tmo_at = rel_cnt; end
    if (rx_valid) begin rxv_cnt++; rx_seen = rx_data; end
    if (ack_anomaly) anom_cnt++;
    if (xfer_done && xfer_timeout) both_cnt++;
    if (!link_req_n) rel_cnt = 0; else rel_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    done_cnt = 0; tmo_cnt = 0; rxv_cnt = 0; anom_cnt = 0; both_cnt = 0; tmo_at = -1;
  endtask

  task automatic issue(input logic rx, input logic [DW-1:0] d);
    for (int k = 0; k < 50 && !cmd_ready; k++) @(negedge clk);
    check("R2 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_rx = rx; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R3 request low after accept", link_req_n, 0);
  endtask

  // microcontroller side: DW shift clock pulses
  task automatic mcu_shift(input logic [DW-1:0] tx_bits, output logic [DW-1:0] got);
    for (int i = DW - 1; i >= 0; i--) begin
      shift_din = tx_bits[i];
      repeat (4) @(negedge clk);
      if (i == 0) check("R3 request held until last edge", link_req_n, 0);
      got[i] = shift_dout;
      shift_clk = 1'b1;
      repeat (4) @(negedge clk);
      shift_clk = 1'b0;
    end
  endtask

  task automatic finish_ack(input string req);
    check({req, " request released"}, link_req_n, 1);
    link_ack_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; cmd_valid = 0; cmd_rx = 0; cmd_wdata = '0;
    link_ack_n = 1'b1; shift_clk = 0; shift_din = 0;
    clear_mon();
    repeat (3) @(negedge clk);
    check("R1 req_n in reset", link_req_n, 1);
    check("R1 ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req_n after reset", link_req_n, 1);
    check("R1 pulses idle", done_cnt + tmo_cnt + rxv_cnt + anom_cnt, 0);
    check("R1 ready after ack seen", cmd_ready, 1);
  endtask

  task automatic test_send(input logic [DW-1:0] d);
    logic [DW-1:0] got;
    clear_mon();
    issue(1'b0, d);
    check("R4 output enable", shift_out_en, 1);
    link_ack_n = 1'b0;
    mcu_shift('0, got);
    check("R4 serial bits", got, d);
    repeat (4) @(negedge clk);
    check("R6 out enable off", shift_out_en, 0);
    finish_ack("R6");
    check("R7 one done", done_cnt, 1);
    check("R7 no rx_valid on send", rxv_cnt, 0);
    check("R11 no timeout", tmo_cnt + both_cnt, 0);
  endtask

  task automatic test_recv(input logic [DW-1:0] d);
    logic [DW-1:0] got;
    clear_mon();
    issue(1'b1, 8'h00);
    check("R4 no drive on receive", shift_out_en, 0);
    link_ack_n = 1'b0;
    mcu_shift(d, got);
    repeat (4) @(negedge clk);
    finish_ack("R6");
    check("R7 one done", done_cnt, 1);
    check("R5 one rx_valid", rxv_cnt, 1);
    check("R5 received byte", rx_seen, d);
    check("R9 no anomaly", anom_cnt, 0);
  endtask

  task automatic test_timeout_and_gate();
    logic [DW-1:0] got;
    clear_mon();
    issue(1'b0, 8'h3C);
    link_ack_n = 1'b0;
    mcu_shift('0, got);
    repeat (TO + 10) @(negedge clk);
    check("R8 one timeout", tmo_cnt, 1);
    check("R8 timeout distance", tmo_at, TO);
    check("R8 no done", done_cnt, 0);
    // ack still low: commands must be refused
    check("R2 not ready while ack low", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_rx = 1'b0; cmd_wdata = 8'hFF;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (link_req_n !== 1'b1) check("R2 request stays high", link_req_n, 1);
    end
    check("R2 request stayed high", link_req_n, 1);
    cmd_valid = 1'b0;
    link_ack_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 ready once ack high", cmd_ready, 1);
  endtask

  task automatic test_anomaly();
    logic [DW-1:0] got;
    clear_mon();
    issue(1'b0, 8'h81);
    mcu_shift('0, got);
    repeat (6) @(negedge clk);
    check("R9 anomaly flagged", anom_cnt, 1);
    check("R9 still done", done_cnt, 1);
    check("R9 data still sent", got, 8'h81);
  endtask

  task automatic test_stray();
    logic [DW-1:0] got;
    clear_mon();
    shift_din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      shift_clk = 1'b1; repeat (4) @(negedge clk);
      shift_clk = 1'b0; repeat (4) @(negedge clk);
    end
    check("R10 idle edges no pulses", done_cnt + rxv_cnt, 0);
    issue(1'b1, 8'h00);
    link_ack_n = 1'b0;
    mcu_shift(8'h12, got);
    // extra edges after release, before acknowledge
    for (int k = 0; k < 3; k++) begin
      shift_din = 1'b1;
      shift_clk = 1'b1; repeat (4) @(negedge clk);
      shift_clk = 1'b0; repeat (4) @(negedge clk);
    end
    check("R6 released after edges", link_req_n, 1);
    finish_ack("R6");
    check("R10 received unaffected", rx_seen, 8'h12);
    clear_mon();
    issue(1'b0, 8'h96);
    link_ack_n = 1'b0;
    mcu_shift('0, got);
    repeat (4) @(negedge clk);
    finish_ack("R6");
    check("R6 next send unaffected", got, 8'h96);
    check("R7 done after stray", done_cnt, 1);
  endtask

  initial begin
    test_reset();
    test_send(8'hA5);
    test_send(8'h5A);
    test_recv(8'h3C);
    test_recv(8'hC3);
    test_timeout_and_gate();
    test_anomaly();
    test_stray();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule